// File: doc/BRIEF.md
# Serial ADC Result Readout Master

This block drives an external successive-approximation ADC that returns its 12-bit result on one serial data line. On a start request it raises a conversion-start strobe for one serial-clock period. It then holds the serial clock low for a fixed conversion wait, clocks the result in most-significant bit first, and presents the 12-bit word with a single-cycle valid pulse. The serial clock idles low, and each bit is captured on the rising edge. The ADC changes its data on the falling edge.

Two readout styles can be chosen for each conversion with `mode_i`. Byte mode issues two 8-clock frames separated by a low gap. The first frame carries result bits 11 to 4. The upper nibble of the second frame carries bits 3 to 0, and the lower nibble of that frame is dropped. Long mode issues a single frame of `LONG_CLKS` clocks (12 to 16), keeps the first 12 bits and drops the rest. The serial clock period is `CLK_DIV` system clocks, an even number of at least 2. Set it so the serial clock stays at or below 8 MHz.

Top module: `adc_serial_rd`

## Requirements
- R1: While and just after reset: `sclk_o`, `cnvst_o`, `busy_o` and `result_valid_o` are low, and `result_o` is zero.
- R2: A start accepted while idle raises `busy_o` and `cnvst_o` in the next cycle. `cnvst_o` stays high for exactly `CLK_DIV` system clocks.
- R3: After `cnvst_o` falls, the serial clock stays low for `CONV_CYCLES` + `CLK_DIV`/2 system clocks before its first rising edge.
- R4: Each serial clock period is low for `CLK_DIV`/2 cycles and then high for `CLK_DIV`/2 cycles. `adc_din_i` is captured at each rising edge, and the first captured bit is the result MSB.
- R5: Byte mode (`mode_i`=0) issues two frames of 8 rising edges. The clock is low for `CLK_DIV` + `CLK_DIV`/2 cycles between the last rise of frame one and the first rise of frame two. Result bits 11..4 come from frame one. Bits 3..0 come from the first four bits of frame two, and its last four bits are ignored.
- R6: Long mode (`mode_i`=1) issues one frame of `LONG_CLKS` rising edges. The result is the first 12 captured bits, and any later bits are ignored.
- R7: `result_valid_o` is high for exactly one cycle after the final falling edge. `busy_o` is low in that cycle. `result_o` changes only with that pulse.
- R8: `start_i` while `busy_o` is high has no effect. `mode_i` is sampled only when a start is accepted.
- R9: `cnvst_o` and `sclk_o` are never high together, and `sclk_o` is low whenever `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one conversion and readout |
| mode_i | input | 1 | 0: two byte frames, 1: one long frame |
| adc_din_i | input | 1 | Serial data from the ADC |
| cnvst_o | output | 1 | Conversion-start strobe |
| sclk_o | output | 1 | Serial clock to the ADC |
| busy_o | output | 1 | Conversion or readout in progress |
| result_valid_o | output | 1 | One-cycle pulse when the result is complete |
| result_o | output | 12 | Assembled conversion result |

## Verification
Some properties are checked on every cycle:
- the valid pulse is one cycle wide and never overlaps busy;
- the result holds between pulses;
- the strobe never overlaps the serial clock;
- the clock is low whenever the block is idle;
- every high phase lasts exactly half a period.

Other behaviour depends on the data and the sequence, so only the bench scenarios can show it:
- which captured bits land in the result;
- that trailing and lower-nibble bits are dropped;
- the frame and rising-edge counts, the conversion wait and the gap between bytes;
- that a start or a mode change in mid-run has no effect.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_CNV,
    S_WAIT,
    S_SHIFT,
    S_GAP,
    S_DONE
  } rd_state_e;

  localparam int unsigned RESULT_W = 12;
  localparam int unsigned BYTE_W   = 8;
endpackage

// File: rtl/adc_rd_clkgen.sv
// Serial clock generator: idles low while disabled, rise/fall strobes mark toggle edges.
module adc_rd_clkgen #(
  parameter int unsigned HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] HALF_M1 = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          sclk_q;
  logic          wrap;

  assign wrap = en_i && (cnt_q == HALF_M1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sclk_o = sclk_q;
  assign rise_o = wrap && !sclk_q;
  assign fall_o = wrap && sclk_q;
endmodule

// File: rtl/adc_rd_shifter.sv
// MSB-first capture register, filled on serial clock rising edges.
module adc_rd_shifter #(
  parameter int unsigned SH_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            shift_i,
  input  logic            din_i,
  output logic [SH_W-1:0] word_o
);
  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (clear_i) sh_q <= '0;
    else if (shift_i) sh_q <= {sh_q[SH_W-2:0], din_i};
  end

  assign word_o = sh_q;
endmodule

// File: rtl/adc_serial_rd.sv
module adc_serial_rd #(
  parameter int unsigned CLK_DIV     = 4,
  parameter int unsigned CONV_CYCLES = 20,
  parameter int unsigned LONG_CLKS   = 14
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        mode_i,
  input  logic        adc_din_i,
  output logic        cnvst_o,
  output logic        sclk_o,
  output logic        busy_o,
  output logic        result_valid_o,
  output logic [11:0] result_o
);
  import adc_rd_pkg::*;

  localparam int unsigned HALF = CLK_DIV / 2;
  localparam int unsigned SH_W = 2 * BYTE_W;
  localparam int unsigned TMAX = (CLK_DIV > CONV_CYCLES) ? CLK_DIV : CONV_CYCLES;
  localparam int unsigned TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] DIV_M1  = TW'(CLK_DIV - 1);
  localparam logic [TW-1:0] CONV_M1 = TW'(CONV_CYCLES - 1);

  rd_state_e state_q;
  logic [TW-1:0]       tmr_q;
  logic [4:0]          per_q;
  logic                frame2_q;
  logic                mode_q;
  logic [RESULT_W-1:0] result_q;

  logic            accept;
  logic            sclk_rise, sclk_fall;
  logic [SH_W-1:0] cap_word;
  logic [SH_W-1:0] aligned;
  logic [4:0]      frame_last;
  logic [2:0]      shamt;

  assign accept     = start_i && (state_q == S_IDLE || state_q == S_DONE);
  assign frame_last = mode_q ? 5'(LONG_CLKS - 1) : 5'(BYTE_W - 1);
  // total bits captured minus 12: byte mode captures 16
  assign shamt      = mode_q ? 3'(LONG_CLKS - RESULT_W) : 3'(SH_W - RESULT_W);
  assign aligned    = cap_word >> shamt;

  adc_rd_clkgen #(.HALF(HALF)) u_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == S_SHIFT),
    .sclk_o (sclk_o),
    .rise_o (sclk_rise),
    .fall_o (sclk_fall)
  );

  adc_rd_shifter #(.SH_W(SH_W)) u_shifter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept),
    .shift_i (sclk_rise),
    .din_i   (adc_din_i),
    .word_o  (cap_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      tmr_q    <= '0;
      per_q    <= '0;
      frame2_q <= 1'b0;
      mode_q   <= 1'b0;
      result_q <= '0;
    end else begin
      case (state_q)
        S_IDLE, S_DONE: begin
          if (accept) begin
            state_q <= S_CNV;
            tmr_q   <= DIV_M1;
            mode_q  <= mode_i;
          end else begin
            state_q <= S_IDLE;
          end
        end
        S_CNV: begin
          if (tmr_q == '0) begin
            state_q <= S_WAIT;
            tmr_q   <= CONV_M1;
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        S_WAIT: begin
          if (tmr_q == '0) begin
            state_q  <= S_SHIFT;
            per_q    <= '0;
            frame2_q <= 1'b0;
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        S_SHIFT: begin
          if (sclk_fall) begin
            if (per_q == frame_last) begin
              if (!mode_q && !frame2_q) begin
                state_q  <= S_GAP;
                tmr_q    <= DIV_M1;
                frame2_q <= 1'b1;
              end else begin
                state_q  <= S_DONE;
                result_q <= aligned[RESULT_W-1:0];
              end
            end else begin
              per_q <= per_q + 1'b1;
            end
          end
        end
        S_GAP: begin
          if (tmr_q == '0) begin
            state_q <= S_SHIFT;
            per_q   <= '0;
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cnvst_o        = (state_q == S_CNV);
  assign busy_o         = (state_q == S_CNV) || (state_q == S_WAIT) ||
                          (state_q == S_SHIFT) || (state_q == S_GAP);
  assign result_valid_o = (state_q == S_DONE);
  assign result_o       = result_q;
endmodule

// File: rtl/adc_serial_rd_chk.sv
module adc_serial_rd_chk #(
  parameter int unsigned CLK_DIV = 4
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cnvst_o,
  input logic        sclk_o,
  input logic        busy_o,
  input logic        result_valid_o,
  input logic [11:0] result_o
);
  localparam int unsigned HALF = CLK_DIV / 2;

  logic [7:0] hi_run;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hi_run <= '0;
    else if (sclk_o) hi_run <= hi_run + 1'b1;
    else             hi_run <= '0;
  end

  assert_cnvst_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnvst_o |-> busy_o);
  assert_high_phase_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> (hi_run == 8'(HALF)));
  assert_valid_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |=> !result_valid_o);
  assert_valid_not_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> !busy_o);
  assert_result_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !result_valid_o |-> $stable(result_o));
  assert_no_overlap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cnvst_o && sclk_o));
  assert_sclk_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sclk_o);
endmodule

bind adc_serial_rd adc_serial_rd_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cnvst_o        (cnvst_o),
  .sclk_o         (sclk_o),
  .busy_o         (busy_o),
  .result_valid_o (result_valid_o),
  .result_o       (result_o)
);

// File: tb/adc_serial_rd_tb.sv
`timescale 1ns/1ps
module adc_serial_rd_tb;
  localparam int DIV  = 4;
  localparam int CONV = 20;
  localparam int LONG = 14;
  localparam int HALF = DIV / 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic mode_i = 1'b0;
  logic adc_din_i = 1'b0;
  logic cnvst_o, sclk_o, busy_o, result_valid_o;
  logic [11:0] result_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk_i = ~clk_i;

  adc_serial_rd #(.CLK_DIV(DIV), .CONV_CYCLES(CONV), .LONG_CLKS(LONG)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .adc_din_i(adc_din_i), .cnvst_o(cnvst_o), .sclk_o(sclk_o), .busy_o(busy_o),
    .result_valid_o(result_valid_o), .result_o(result_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic bit_for(input int k, input logic [11:0] w, input logic [3:0] j);
    if (k < 12) return w[11-k];
    if (k < 16) return j[15-k];
    return 1'b0;
  endfunction

  task automatic t_reset();
    check(sclk_o == 1'b0, "R1 sclk", sclk_o, 0);
    check(cnvst_o == 1'b0, "R1 cnvst", cnvst_o, 0);
    check(busy_o == 1'b0, "R1 busy", busy_o, 0);
    check(result_valid_o == 1'b0, "R1 valid", result_valid_o, 0);
    check(result_o == 12'h000, "R1 result", result_o, 0);
  endtask

  // One readout; disturb pulses start and flips mode in mid-run (R8).
  task automatic t_readout(input logic m, input logic [11:0] w, input logic [3:0] j,
                           input bit disturb);
    int cnv_cnt = 0, rises = 0, first_low = -1, gap_low = -1;
    int low_run = 0, high_run = 0, bad_low = 0, bad_high = 0;
    int overlap = 0, busy_bad = 0, iter = 0;
    bit cnv_seen = 0, prev_sclk = 0, got_valid = 0;
    int exp_rises = m ? LONG : 16;
    @(negedge clk_i);
    mode_i = m; start_i = 1'b1; adc_din_i = bit_for(0, w, j);
    @(negedge clk_i);
    start_i = 1'b0;
    while (iter < 2000) begin
      if (disturb && iter == 30) begin start_i = 1'b1; mode_i = ~m; end
      if (disturb && iter == 31) start_i = 1'b0;
      if (cnvst_o) begin cnv_cnt++; cnv_seen = 1; end
      if (cnvst_o && sclk_o) overlap++;
      if (result_valid_o) begin got_valid = 1; break; end
      if (!busy_o) busy_bad++;
      if (sclk_o && !prev_sclk) begin
        rises++;
        if (rises == 1) first_low = low_run;
        else if (!m && rises == 9) gap_low = low_run;
        else if (low_run != HALF) bad_low++;
        low_run = 0;
      end
      if (!sclk_o && prev_sclk) begin
        if (high_run != HALF) bad_high++;
        high_run = 0;
      end
      if (sclk_o) high_run++;
      else if (cnv_seen && !cnvst_o) low_run++;
      if (!sclk_o) adc_din_i = bit_for(rises, w, j);
      prev_sclk = sclk_o;
      iter++;
      @(negedge clk_i);
    end
    check(got_valid, "R7 valid seen", got_valid, 1);
    check(result_o == w, m ? "R6 long result" : "R5 byte result", result_o, w);
    check(rises == exp_rises, m ? "R6 rise count" : "R5 rise count", rises, exp_rises);
    check(cnv_cnt == DIV, "R2 cnvst width", cnv_cnt, DIV);
    check(busy_bad == 0, "R2 busy held", busy_bad, 0);
    check(first_low == CONV + HALF, "R3 conversion wait", first_low, CONV + HALF);
    check(bad_low == 0 && bad_high == 0, "R4 clock phases", bad_low + bad_high, 0);
    check(overlap == 0, "R9 cnvst/sclk overlap", overlap, 0);
    if (!m) check(gap_low == DIV + HALF, "R5 byte gap", gap_low, DIV + HALF);
    check(busy_o == 1'b0 && sclk_o == 1'b0, "R7 busy low at valid", busy_o, 0);
    @(negedge clk_i);
    check(result_valid_o == 1'b0, "R7 valid one cycle", result_valid_o, 0);
    repeat (30) begin
      if (busy_o || cnvst_o) busy_bad++;
      @(negedge clk_i);
    end
    check(busy_bad == 0, "R8 no second run", busy_bad, 0);
    check(result_o == w, "R7 result held", result_o, w);
    mode_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_readout(1'b0, 12'hA5C, 4'b0101, 1'b0);   // R5
    t_readout(1'b1, 12'h3F1, 4'b1010, 1'b0);   // R6 trailing ones/zeros
    t_readout(1'b0, 12'h000, 4'b1111, 1'b0);   // R5 lower nibble all ones
    t_readout(1'b1, 12'hFFF, 4'b0000, 1'b0);   // R6
    t_readout(1'b0, 12'h6B3, 4'b1001, 1'b1);   // R8 start and mode change ignored
    t_readout(1'b1, 12'h812, 4'b1100, 1'b1);   // R8
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule